// File: doc/BRIEF.md
# Checksummed Command Frame Receiver

This block sits behind a byte-oriented serial receiver. Each incoming byte arrives with a one-clock valid strobe, and a separate pulse reports a receive timeout. The block hunts for a function code, then takes a length byte, that many payload bytes and a final checksum byte. It checks the frame and keeps it in an internal buffer. A downstream command executor is told about the frame with a single-clock done pulse and reads the payload by index.

A frame with a bad function code, an oversized length, a bad checksum or a timeout part way through is dropped without a reply. Each dropped frame adds one to a wrapping error counter, and the receiver goes back to hunting. After a good frame the receiver holds the buffer untouched until the consumer gives a release strobe. It ignores the link while it waits.

Top module: `frame_rx`

## Requirements
- R1: After reset, frm_done is 0, frm_func and frm_len are 0, err_cnt is 0 and the receiver is hunting for a function code.
- R2: While hunting, a byte below 0xF0 is discarded and increments err_cnt by one. A byte of 0xF0 or above is taken as the function code.
- R3: A length byte above 128 ends the frame, increments err_cnt and returns to hunting. A length of exactly 128 is accepted.
- R4: Exactly the announced number of payload bytes follow the length, then one checksum byte. With length 0 the next byte after the length is the checksum.
- R5: A frame is accepted only if the 8-bit sum of function code, length, payload and checksum is 0 modulo 256. Otherwise it is dropped without a done pulse and err_cnt increments.
- R6: A timeout pulse while a frame is in progress, past the function code, aborts it and increments err_cnt. The timeout wins over a byte that arrives in the same cycle. A timeout while hunting has no effect.
- R7: frm_done is high for exactly one clock, in the cycle after the checksum byte is taken. frm_func and frm_len then show the frame's code and length and hold them until the next good frame.
- R8: The buffer holds the function code at index 0, the length at index 1, payload byte i at index 2+i and the checksum at index 2+length. rd_data shows the entry at rd_idx one clock after rd_idx is presented.
- R9: After a good frame, received bytes and timeouts are ignored until consumer_release is high for a clock. Hunting then resumes. Release at any other time has no effect.
- R10: err_cnt is 8 bits wide and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a new byte this cycle |
| rx_timeout | input | 1 | Receive timeout pulse |
| consumer_release | input | 1 | Consumer has finished with the held frame |
| rd_idx | input | 8 | Buffer read index |
| rd_data | output | 8 | Buffer entry at the previous cycle's rd_idx |
| frm_done | output | 1 | One-clock pulse for a good frame |
| frm_func | output | 8 | Function code of the last good frame |
| frm_len | output | 8 | Payload length of the last good frame |
| err_cnt | output | 8 | Count of rejected frames and discarded code bytes |

## Verification
The bench targets several boundaries:
- 0xEF against 0xF0 as the first byte. A floor off by one would accept a bad code or drop a good one.
- Length 128 against 129. An off-by-one here either rejects the largest legal frame or overruns the buffer.
- A zero-length frame. A receiver that always waits for payload would swallow the checksum.
- A timeout arriving together with a byte. If the byte won, it would be taken as data.

It also feeds a complete valid frame while a frame is held. A missing hold state would give a second done pulse and overwrite the buffer. Finally it wraps the error counter past 255.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef enum logic [2:0] {
    S_HUNT,
    S_LEN,
    S_DATA,
    S_SUM,
    S_HOLD
  } frx_state_e;
endpackage

// File: rtl/frx_sum.sv
module frx_sum #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              add,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] sum_o
);
  always_ff @(posedge clk) begin
    if (rst)       sum_o <= '0;
    else if (load) sum_o <= din;
    else if (add)  sum_o <= sum_o + din;
  end

  p_load_clears_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (sum_o == $past(din)));
endmodule

// File: rtl/frx_buf.sv
module frx_buf #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 131,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [BYTE_W-1:0] wd,
  input  logic [IDX_W-1:0]  ra,
  output logic [BYTE_W-1:0] rd
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/frx_ctrl.sv
module frx_ctrl
  import frx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int FUNC_MIN = 8'hF0,
  parameter int MAX_LEN  = 128,
  parameter int ERR_W    = 8,
  parameter int IDX_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_timeout,
  input  logic              consumer_release,
  input  logic [BYTE_W-1:0] sum_q,
  output logic              sum_load,
  output logic              sum_add,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_wa,
  output logic              frm_done,
  output logic [BYTE_W-1:0] frm_func,
  output logic [BYTE_W-1:0] frm_len,
  output logic [ERR_W-1:0]  err_cnt
);
  frx_state_e        st;
  logic [BYTE_W-1:0] func_r, len_r, cnt_r;
  logic              in_frame, abort, code_ok, len_ok, sum_ok;

  assign in_frame = (st == S_LEN) || (st == S_DATA) || (st == S_SUM);
  assign abort    = in_frame && rx_timeout;
  assign code_ok  = rx_data >= BYTE_W'(FUNC_MIN);
  assign len_ok   = rx_data <= BYTE_W'(MAX_LEN);
  assign sum_ok   = (sum_q + rx_data) == '0;

  always_comb begin
    sum_load = 1'b0;
    sum_add  = 1'b0;
    buf_we   = 1'b0;
    buf_wa   = '0;
    if (rx_valid && !abort) begin
      case (st)
        S_HUNT: begin sum_load = code_ok; buf_we = code_ok; buf_wa = '0; end
        S_LEN:  begin sum_add = len_ok; buf_we = len_ok; buf_wa = IDX_W'(1); end
        S_DATA: begin sum_add = 1'b1; buf_we = 1'b1; buf_wa = IDX_W'(2) + IDX_W'(cnt_r); end
        S_SUM:  begin buf_we = 1'b1; buf_wa = IDX_W'(2) + IDX_W'(len_r); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_HUNT;
      func_r   <= '0;
      len_r    <= '0;
      cnt_r    <= '0;
      frm_done <= 1'b0;
      frm_func <= '0;
      frm_len  <= '0;
      err_cnt  <= '0;
    end else begin
      frm_done <= 1'b0;
      if (abort) begin
        err_cnt <= err_cnt + ERR_W'(1);
        st      <= S_HUNT;
      end else begin
        case (st)
          S_HUNT: if (rx_valid) begin
            if (code_ok) begin
              func_r <= rx_data;
              st     <= S_LEN;
            end else begin
              err_cnt <= err_cnt + ERR_W'(1);
            end
          end
          S_LEN: if (rx_valid) begin
            if (!len_ok) begin
              err_cnt <= err_cnt + ERR_W'(1);
              st      <= S_HUNT;
            end else begin
              len_r <= rx_data;
              cnt_r <= '0;
              st    <= (rx_data == '0) ? S_SUM : S_DATA;
            end
          end
          S_DATA: if (rx_valid) begin
            cnt_r <= cnt_r + BYTE_W'(1);
            if (cnt_r == len_r - BYTE_W'(1)) st <= S_SUM;
          end
          S_SUM: if (rx_valid) begin
            if (sum_ok) begin
              frm_done <= 1'b1;
              frm_func <= func_r;
              frm_len  <= len_r;
              st       <= S_HOLD;
            end else begin
              err_cnt <= err_cnt + ERR_W'(1);
              st      <= S_HUNT;
            end
          end
          S_HOLD: if (consumer_release) st <= S_HUNT;
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    frm_done |=> !frm_done);
  p_len_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
    frm_done |-> (frm_len <= BYTE_W'(MAX_LEN)));
  p_func_floor_r2: assert property (@(posedge clk) disable iff (rst)
    frm_done |-> (frm_func >= BYTE_W'(FUNC_MIN)));
  p_err_step_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + ERR_W'(1)));
  p_hold_sticks_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && !consumer_release) |=> (st == S_HOLD) && $stable(err_cnt));
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA) |-> (cnt_r < len_r));
  p_timeout_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (in_frame && rx_timeout) |=> (st == S_HUNT) && !frm_done);
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int BYTE_W   = 8,
  parameter int FUNC_MIN = 8'hF0,
  parameter int MAX_LEN  = 128,
  parameter int ERR_W    = 8,
  localparam int DEPTH   = MAX_LEN + 3,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_timeout,
  input  logic              consumer_release,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic              frm_done,
  output logic [BYTE_W-1:0] frm_func,
  output logic [BYTE_W-1:0] frm_len,
  output logic [ERR_W-1:0]  err_cnt
);
  logic              sum_load, sum_add, buf_we;
  logic [BYTE_W-1:0] sum_q;
  logic [IDX_W-1:0]  buf_wa;

  frx_ctrl #(
    .BYTE_W(BYTE_W), .FUNC_MIN(FUNC_MIN), .MAX_LEN(MAX_LEN),
    .ERR_W(ERR_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_timeout(rx_timeout), .consumer_release(consumer_release),
    .sum_q(sum_q), .sum_load(sum_load), .sum_add(sum_add),
    .buf_we(buf_we), .buf_wa(buf_wa), .frm_done(frm_done),
    .frm_func(frm_func), .frm_len(frm_len), .err_cnt(err_cnt)
  );

  frx_sum #(.BYTE_W(BYTE_W)) u_sum (
    .clk(clk), .rst(rst), .load(sum_load), .add(sum_add),
    .din(rx_data), .sum_o(sum_q)
  );

  frx_buf #(.BYTE_W(BYTE_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .we(buf_we), .wa(buf_wa), .wd(rx_data),
    .ra(rd_idx), .rd(rd_data)
  );
endmodule

// File: tb/tb_frame_rx.sv
`timescale 1ns/1ps
module tb_frame_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       rx_timeout = 1'b0;
  logic       consumer_release = 1'b0;
  logic [7:0] rd_idx = '0;
  logic [7:0] rd_data, frm_func, frm_len, err_cnt;
  logic       frm_done;

  int n_chk = 0, n_bad = 0, cyc = 0, exp_err = 0;

  always #2 clk = ~clk;

  frame_rx dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_timeout(rx_timeout), .consumer_release(consumer_release),
    .rd_idx(rd_idx), .rd_data(rd_data), .frm_done(frm_done),
    .frm_func(frm_func), .frm_len(frm_len), .err_cnt(err_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 0, m_func = 0, m_len = 0, m_cnt = 0, m_sum = 0, m_err = 0;
  int m_done = 0, m_ofunc = 0, m_olen = 0, m_rd = -1;
  int m_mem [131];
  initial for (int i = 0; i < 131; i++) m_mem[i] = -1;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_err = 0; m_done = 0; m_ofunc = 0; m_olen = 0; m_rd = -1;
    end else begin
      m_rd = (rd_idx < 131) ? m_mem[rd_idx] : -1;
      m_done = 0;
      if (m_st >= 1 && m_st <= 3 && rx_timeout) begin
        m_err = (m_err + 1) % 256; m_st = 0;
      end else if (m_st == 4) begin
        if (consumer_release) m_st = 0;
      end else if (rx_valid) begin
        case (m_st)
          0: if (rx_data >= 8'hF0) begin
               m_func = rx_data; m_sum = rx_data; m_mem[0] = rx_data; m_st = 1;
             end else m_err = (m_err + 1) % 256;
          1: if (rx_data > 128) begin m_err = (m_err + 1) % 256; m_st = 0; end
             else begin
               m_len = rx_data; m_cnt = 0; m_sum = (m_sum + rx_data) % 256;
               m_mem[1] = rx_data; m_st = (rx_data == 0) ? 3 : 2;
             end
          2: begin
               m_mem[2 + m_cnt] = rx_data; m_sum = (m_sum + rx_data) % 256;
               m_cnt++; if (m_cnt == m_len) m_st = 3;
             end
          default: begin
               m_mem[2 + m_len] = rx_data;
               if ((m_sum + rx_data) % 256 == 0) begin
                 m_done = 1; m_ofunc = m_func; m_olen = m_len; m_st = 4;
               end else begin m_err = (m_err + 1) % 256; m_st = 0; end
             end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(frm_done == m_done[0], "R7 done vs model", frm_done, m_done);
      chk(frm_func == m_ofunc, "R7 func vs model", frm_func, m_ofunc);
      chk(frm_len == m_olen, "R7 len vs model", frm_len, m_olen);
      chk(err_cnt == m_err, "R2 R3 R5 R6 err vs model", err_cnt, m_err);
      if (m_rd >= 0) chk(rd_data == m_rd, "R8 rd_data vs model", rd_data, m_rd);
    end
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic int pay(input int f, input int i);
    return (f * 7 + i * 13 + 5) % 256;
  endfunction

  task automatic send(input int b);
    rx_data = b[7:0]; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input int f, input int n, input int corrupt);
    int s = f + n;
    send(f); send(n);
    for (int i = 0; i < n; i++) begin send(pay(f, i)); s += pay(f, i); end
    send(((256 - (s % 256)) + corrupt) % 256);
  endtask

  task automatic pulse_release();
    consumer_release = 1'b1; @(negedge clk); consumer_release = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input int exp, input string req);
    rd_idx = idx[7:0]; @(negedge clk);
    chk(rd_data == exp[7:0], req, rd_data, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(frm_done == 0 && frm_func == 0 && frm_len == 0, "R1 outputs after reset", frm_func, 0);
    chk(err_cnt == 0, "R1 err_cnt after reset", err_cnt, 0);

    // good frame, R7 and R8
    send_frame(8'hF5, 3, 0);
    chk(frm_done == 1, "R7 done after checksum", frm_done, 1);
    chk(frm_func == 8'hF5, "R7 func", frm_func, 8'hF5);
    chk(frm_len == 3, "R7 len", frm_len, 3);
    @(negedge clk);
    chk(frm_done == 0, "R7 done one clock", frm_done, 0);
    rd_chk(0, 8'hF5, "R8 index 0 func");
    rd_chk(1, 3, "R8 index 1 len");
    for (int i = 0; i < 3; i++) rd_chk(2 + i, pay(8'hF5, i), "R8 payload");
    rd_chk(5, (256 - ((8'hF5 + 3 + pay(8'hF5,0) + pay(8'hF5,1) + pay(8'hF5,2)) % 256)) % 256,
           "R8 checksum slot");

    // R9 hold ignores a whole valid frame and timeouts
    send_frame(8'hF1, 1, 0);
    chk(frm_done == 0, "R9 no done while held", frm_done, 0);
    rx_timeout = 1'b1; @(negedge clk); rx_timeout = 1'b0;
    chk(frm_func == 8'hF5 && err_cnt == 0, "R9 held state unchanged", err_cnt, 0);
    rd_chk(0, 8'hF5, "R9 buffer untouched");
    pulse_release();

    // R4 zero length
    send(8'hF2); send(0); send(8'h0E);
    chk(frm_done == 1 && frm_len == 0, "R4 zero length frame", frm_len, 0);
    rd_chk(2, 8'h0E, "R4 checksum at index 2");
    pulse_release();

    // R2 function floor
    send(8'h3C); exp_err++;
    chk(err_cnt == exp_err, "R2 low code discarded", err_cnt, exp_err);
    send(8'hEF); exp_err++;
    chk(err_cnt == exp_err, "R2 0xEF discarded", err_cnt, exp_err);
    send_frame(8'hF0, 1, 0);
    chk(frm_done == 1 && frm_func == 8'hF0, "R2 0xF0 accepted", frm_func, 8'hF0);
    pulse_release();

    // R3 length ceiling
    send(8'hF3); send(129); exp_err++;
    chk(err_cnt == exp_err, "R3 length 129 rejected", err_cnt, exp_err);
    send_frame(8'hF3, 128, 0);
    chk(frm_done == 1 && frm_len == 128, "R3 length 128 accepted", frm_len, 128);
    rd_chk(129, pay(8'hF3, 127), "R8 last payload byte");
    pulse_release();

    // R5 bad checksum
    send_frame(8'hF4, 2, 1); exp_err++;
    chk(frm_done == 0, "R5 no done on bad sum", frm_done, 0);
    chk(err_cnt == exp_err, "R5 bad sum counted", err_cnt, exp_err);

    // R6 timeouts
    send(8'hF6); send(3); send(9);
    rx_timeout = 1'b1; @(negedge clk); rx_timeout = 1'b0; exp_err++;
    chk(err_cnt == exp_err, "R6 timeout mid data", err_cnt, exp_err);
    rx_timeout = 1'b1; @(negedge clk); rx_timeout = 1'b0;
    chk(err_cnt == exp_err, "R6 timeout while hunting ignored", err_cnt, exp_err);
    send(8'hF7); send(1);
    rx_timeout = 1'b1; send(8'h55); rx_timeout = 1'b0; exp_err++;
    chk(err_cnt == exp_err, "R6 timeout beats byte", err_cnt, exp_err);
    send_frame(8'hF8, 2, 0);
    chk(frm_done == 1 && frm_func == 8'hF8, "R6 resync after timeout", frm_func, 8'hF8);
    pulse_release();

    // R10 wrap
    for (int i = exp_err; i < 256; i++) send(8'h01);
    chk(err_cnt == 0, "R10 err_cnt wraps", err_cnt, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule